// File: doc/BRIEF.md
# Auto-Increment Table Upload Port

This block sits behind a register-write bus and turns writes to data-port register ids into writes of on-chip tables. Six tables are served: a vertex program store, a vertex operand-pattern store, a geometry program store, a geometry operand-pattern store, a fog table and a lighting table that holds several table types. Each table keeps a write cursor. Software sets the cursor through an offset register id. It then streams words through any of eight data ids. Each word lands at the cursor, and the cursor then moves up by one.

The program and pattern stores reject a word once their cursor has reached the store depth. The rejected word raises a one-cycle error and does not move the cursor. The fog and lighting tables wrap their cursor instead. Unless the exclusive-configuration input is set, a word accepted by a vertex store is copied to the same address of the matching geometry store. The copy does not move the geometry cursor. All outputs are registered and appear one clock after the register write. The per-table write strobe also serves as the table's dirty pulse.

Top module: `upl_port`

## Requirements
- R1: Each table decodes eight data ids, `0x108+16*t` to `0x10F+16*t`. A write to any of them writes `wr_data` at the table's cursor and then adds one to the cursor. Table numbers t are 0 vertex program, 1 vertex pattern, 2 geometry program, 3 geometry pattern, 4 fog and 5 lighting.
- R2: A geometry program write is accepted only while the cursor is below `GPROG_DEPTH` (4096). A write at or above that bound gives no table write and an `err` pulse, and the cursor keeps its value.
- R3: A vertex program write is accepted only while the cursor is below `VPROG_DEPTH` (512). Rejection behaves as in R2.
- R4: When `excl_cfg` is 0 in the cycle of the write, an accepted vertex program or vertex pattern write is also written to the same address of the geometry program or geometry pattern store. The geometry cursor does not change. When `excl_cfg` is 1, no copy is made.
- R5: The fog cursor counts modulo `FOG_DEPTH` (128). A write to the fog offset register stores `wr_data[15:0]` modulo 128, and fog writes never raise `err`.
- R6: For the lighting offset id, `wr_data[7:0]` is the index and `wr_data[12:8]` is the table type. Each lighting write goes to (`lut_type`, index), and the index then counts modulo 256 without error.
- R7: A write to an offset id, `0x100+16*t`, loads the cursor from `wr_data[15:0]` with no table write and no error. The next data write to that table uses the loaded value.
- R8: The two pattern stores are `PAT_DEPTH` (128) deep and reject out-of-range writes as in R2.
- R9: Outputs are registered. `tbl_we` bit t pulses high for exactly the cycle after each accepted write to table t, or after a copy into it. `tbl_data` carries the written word in that cycle.
- R10: Ids outside the offset and data ids listed here, and any cycle with `wr_en` low, cause no table write, no error and no cursor change.
- R11: After reset every cursor and the lighting type are 0, and `tbl_we` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write valid |
| wr_id | input | 10 | Register id |
| wr_data | input | 32 | Register write value |
| excl_cfg | input | 1 | 1 stops copies from vertex stores into geometry stores |
| tbl_we | output | 6 | Per-table write strobe / dirty pulse, bit = table number |
| tbl_data | output | 32 | Word being written |
| vprog_addr | output | 9 | Vertex program address |
| vpat_addr | output | 7 | Vertex pattern address |
| gprog_addr | output | 12 | Geometry program address |
| gpat_addr | output | 7 | Geometry pattern address |
| fog_addr | output | 7 | Fog table address |
| lut_type | output | 5 | Lighting table type |
| lut_addr | output | 8 | Lighting table index |
| err | output | 1 | One-cycle pulse for a rejected write |

## Verification
One accepted vertex write can drive two tables in the same cycle: its own store, and the geometry store it is copied into. The geometry cursor must keep its own value while this happens. The bench provokes this by toggling `excl_cfg` between vertex writes and then writing to the geometry store directly. The bench's model predicts both strobes, both addresses and the untouched geometry cursor, and every output is compared against that model.

// File: rtl/upl_pkg.sv
package upl_pkg;
    localparam int NTBL    = 6;
    localparam int T_VPROG = 0;
    localparam int T_VPAT  = 1;
    localparam int T_GPROG = 2;
    localparam int T_GPAT  = 3;
    localparam int T_FOG   = 4;
    localparam int T_LUT   = 5;
    localparam logic [1:0] ID_PAGE = 2'b01;
endpackage

// File: rtl/upl_decode.sv
module upl_decode
    import upl_pkg::*;
(
    input  logic            en,
    input  logic [9:0]      id,
    output logic [NTBL-1:0] ld,
    output logic [NTBL-1:0] step
);
    logic [3:0] tsel;
    logic [3:0] sub;
    logic       hit;

    assign tsel = id[7:4];
    assign sub  = id[3:0];
    assign hit  = en && (id[9:8] == ID_PAGE);

    always_comb begin
        ld   = '0;
        step = '0;
        for (int t = 0; t < NTBL; t++) begin
            if (hit && tsel == 4'(t)) begin
                ld[t]   = (sub == 4'd0);
                step[t] = sub[3];
            end
        end
    end
endmodule

// File: rtl/upl_cursor.sv
module upl_cursor #(
    parameter int OFS_W = 16,
    parameter int LIMIT = 512,
    parameter bit WRAP  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [OFS_W-1:0] ld_val,
    input  logic             step,
    output logic [OFS_W-1:0] ofs,
    output logic             accept
);
    localparam logic [OFS_W-1:0] LIM = OFS_W'(LIMIT);

    logic in_range;
    assign in_range = WRAP || (ofs < LIM);
    assign accept   = step && in_range;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs <= '0;
        end else if (ld) begin
            ofs <= WRAP ? (ld_val % LIM) : ld_val;
        end else if (accept) begin
            ofs <= WRAP ? ((ofs + 1'b1) % LIM) : (ofs + 1'b1);
        end
    end
endmodule

// File: rtl/upl_port.sv
module upl_port
    import upl_pkg::*;
#(
    parameter int DW          = 32,
    parameter int OFS_W       = 16,
    parameter int VPROG_DEPTH = 512,
    parameter int GPROG_DEPTH = 4096,
    parameter int PAT_DEPTH   = 128,
    parameter int FOG_DEPTH   = 128,
    parameter int LUT_DEPTH   = 256,
    parameter int TYPE_W      = 5,
    localparam int VA_W = $clog2(VPROG_DEPTH),
    localparam int GA_W = $clog2(GPROG_DEPTH),
    localparam int PA_W = $clog2(PAT_DEPTH),
    localparam int FA_W = $clog2(FOG_DEPTH),
    localparam int LA_W = $clog2(LUT_DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [9:0]      wr_id,
    input  logic [DW-1:0]   wr_data,
    input  logic            excl_cfg,
    output logic [5:0]      tbl_we,
    output logic [DW-1:0]   tbl_data,
    output logic [VA_W-1:0] vprog_addr,
    output logic [PA_W-1:0] vpat_addr,
    output logic [GA_W-1:0] gprog_addr,
    output logic [PA_W-1:0] gpat_addr,
    output logic [FA_W-1:0] fog_addr,
    output logic [TYPE_W-1:0] lut_type,
    output logic [LA_W-1:0] lut_addr,
    output logic            err
);
    localparam int LIMS [NTBL] = '{VPROG_DEPTH, PAT_DEPTH, GPROG_DEPTH,
                                   PAT_DEPTH, FOG_DEPTH, LUT_DEPTH};
    localparam bit WRAPS [NTBL] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

    logic [NTBL-1:0]  ld, step, acc;
    logic [OFS_W-1:0] ofs [NTBL];
    logic [NTBL-1:0]  we_n;
    logic [GA_W-1:0]  gaddr_n;
    logic [PA_W-1:0]  gpaddr_n;
    logic             unused_hi;

    upl_decode u_dec (
        .en   (wr_en),
        .id   (wr_id),
        .ld   (ld),
        .step (step)
    );

    for (genvar t = 0; t < NTBL; t++) begin : g_cur
        upl_cursor #(
            .OFS_W (OFS_W),
            .LIMIT (LIMS[t]),
            .WRAP  (WRAPS[t])
        ) u_cur (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (ld[t]),
            .ld_val (wr_data[OFS_W-1:0]),
            .step   (step[t]),
            .ofs    (ofs[t]),
            .accept (acc[t])
        );
    end

    assign unused_hi = ^{ofs[T_VPROG][OFS_W-1:VA_W], ofs[T_VPAT][OFS_W-1:PA_W],
                         ofs[T_GPROG][OFS_W-1:GA_W], ofs[T_GPAT][OFS_W-1:PA_W],
                         ofs[T_FOG][OFS_W-1:FA_W], ofs[T_LUT][OFS_W-1:LA_W]};

    always_comb begin
        we_n     = acc;
        gaddr_n  = ofs[T_GPROG][GA_W-1:0];
        gpaddr_n = ofs[T_GPAT][PA_W-1:0];
        if (acc[T_VPROG] && !excl_cfg) begin
            we_n[T_GPROG] = 1'b1;
            gaddr_n       = GA_W'(ofs[T_VPROG][VA_W-1:0]);
        end
        if (acc[T_VPAT] && !excl_cfg) begin
            we_n[T_GPAT] = 1'b1;
            gpaddr_n     = ofs[T_VPAT][PA_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_we     <= '0;
            tbl_data   <= '0;
            vprog_addr <= '0;
            vpat_addr  <= '0;
            gprog_addr <= '0;
            gpat_addr  <= '0;
            fog_addr   <= '0;
            lut_addr   <= '0;
            lut_type   <= '0;
            err        <= 1'b0;
        end else begin
            tbl_we     <= we_n;
            err        <= |(step & ~acc);
            vprog_addr <= ofs[T_VPROG][VA_W-1:0];
            vpat_addr  <= ofs[T_VPAT][PA_W-1:0];
            gprog_addr <= gaddr_n;
            gpat_addr  <= gpaddr_n;
            fog_addr   <= ofs[T_FOG][FA_W-1:0];
            lut_addr   <= ofs[T_LUT][LA_W-1:0];
            if (|acc) tbl_data <= wr_data;
            if (ld[T_LUT]) lut_type <= wr_data[8 +: TYPE_W];
        end
    end
endmodule

// File: rtl/upl_port_chk.sv
module upl_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [9:0]  wr_id,
    input logic        excl_cfg,
    input logic [5:0]  tbl_we,
    input logic [8:0]  vprog_addr,
    input logic [11:0] gprog_addr,
    input logic [6:0]  fog_addr,
    input logic        err
);
    p_reject_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (tbl_we == 6'd0));

    p_vprog_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we[0] && $past(tbl_we[0])) |-> vprog_addr == $past(vprog_addr) + 9'd1);

    p_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we[0] && !$past(excl_cfg)) |-> (tbl_we[2] && gprog_addr == 12'(vprog_addr)));

    p_fog_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we[4] && $past(tbl_we[4])) |-> fog_addr == $past(fog_addr) + 7'd1);

    p_fog_no_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_id[9:4] == 6'h14 && wr_id[3]) |=> !err);

    p_ofs_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_id[9:8] == 2'b01 && wr_id[3:0] == 4'd0) |=> (tbl_we == 6'd0 && !err));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (tbl_we == 6'd0 && !err));
endmodule

bind upl_port upl_port_chk chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_id      (wr_id),
    .excl_cfg   (excl_cfg),
    .tbl_we     (tbl_we),
    .vprog_addr (vprog_addr),
    .gprog_addr (gprog_addr),
    .fog_addr   (fog_addr),
    .err        (err)
);

// File: tb/upl_port_test.sv
module upl_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int LIM [6] = '{512, 128, 4096, 128, 128, 256};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  wr_id = '0;
    logic [31:0] wr_data = '0;
    logic        excl_cfg = 1'b0;
    logic [5:0]  tbl_we;
    logic [31:0] tbl_data;
    logic [8:0]  vprog_addr;
    logic [6:0]  vpat_addr;
    logic [11:0] gprog_addr;
    logic [6:0]  gpat_addr;
    logic [6:0]  fog_addr;
    logic [4:0]  lut_type;
    logic [7:0]  lut_addr;
    logic        err;

    int n_run = 0;
    int n_fail = 0;
    int mofs [6];
    int mtype = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    upl_port uut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input int t);
        case (t)
            0: return "R3";
            1: return "R8";
            2: return "R2";
            3: return "R8";
            4: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic int addr_of(input int t);
        case (t)
            0: return int'(vprog_addr);
            1: return int'(vpat_addr);
            2: return int'(gprog_addr);
            3: return int'(gpat_addr);
            4: return int'(fog_addr);
            default: return int'(lut_addr);
        endcase
    endfunction

    task automatic wr(input int id, input int data);
        int t, sub, ew, ee;
        int ea [6];
        string tg;
        bit mapped;
        for (int i = 0; i < 6; i++) ea[i] = 0;
        ew = 0; ee = 0; tg = "R10";
        t = (id - 'h100) >>> 4;
        sub = id & 15;
        mapped = (id >= 'h100) && (id < 'h160) && (sub == 0 || sub >= 8);
        if (mapped && sub == 0) begin
            tg = "R7";
            if (t == 4) mofs[t] = (data & 'hFFFF) % 128;
            else if (t == 5) begin mofs[t] = data & 'hFF; mtype = (data >> 8) & 31; end
            else mofs[t] = data & 'hFFFF;
        end else if (mapped) begin
            tg = tag_of(t);
            if (t >= 4) begin
                ew[t] = 1; ea[t] = mofs[t]; mofs[t] = (mofs[t] + 1) % LIM[t];
            end else if (mofs[t] < LIM[t]) begin
                ew[t] = 1; ea[t] = mofs[t];
                if (t < 2 && !excl_cfg) begin ew[t+2] = 1; ea[t+2] = mofs[t]; tg = "R4"; end
                mofs[t] = mofs[t] + 1;
            end else ee = 1;
        end
        @(negedge clk);
        wr_en = 1'b1; wr_id = 10'(id); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        chk(int'(tbl_we) == ew, {tg, " R9 strobe"}, int'(tbl_we), ew);
        chk(int'(err) == ee, {tg, " err"}, int'(err), ee);
        for (int i = 0; i < 6; i++)
            if (ew[i]) chk(addr_of(i) == ea[i], {tg, " R1 addr"}, addr_of(i), ea[i]);
        if (ew != 0) chk(tbl_data == data, {tg, " data"}, tbl_data, data);
        if (ew[5]) chk(int'(lut_type) == mtype, "R6 type", int'(lut_type), mtype);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int r, t, id, d;
        void'($urandom(32'd1234));
        for (int i = 0; i < 6; i++) mofs[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tbl_we == 6'd0 && !err, "R11 reset strobes", int'(tbl_we), 0);
        // R11: cursors start at zero
        wr('h108, 'h11);
        wr('h12F, 'h22);
        // R3: vertex program bound
        wr('h100, 510);
        wr('h10A, 1); wr('h10F, 2); wr('h10C, 3); wr('h10C, 4);
        // R2: geometry program bound, mirror off then direct writes
        excl_cfg = 1'b1;
        wr('h100, 5); wr('h109, 'hA5);
        excl_cfg = 1'b0;
        wr('h120, 4094); wr('h128, 7); wr('h109, 8); wr('h12B, 9); wr('h12E, 10);
        // R8: pattern bound with mirror
        wr('h110, 127); wr('h118, 'h55); wr('h11F, 'h56);
        // R5: fog wraps
        wr('h140, 'h1FE); wr('h148, 1); wr('h149, 2); wr('h14A, 3);
        // R6: lighting index wraps, type loaded
        wr('h150, 'h13FE); wr('h158, 1); wr('h15F, 2); wr('h15C, 3);
        // R10: unmapped ids
        wr('h101, 9); wr('h167, 9); wr('h008, 9); wr('h3F8, 9);
        wr('h108, 'h33);
        for (int k = 0; k < 600; k++) begin
            if ($urandom % 16 == 0) excl_cfg = ~excl_cfg;
            t = int'($urandom % 6);
            r = int'($urandom % 16);
            if (r < 2) begin
                id = 'h100 + 16 * t;
                d = (t >= 4) ? int'($urandom % 65536) : LIM[t] - 4 + int'($urandom % 8);
            end else if (r < 3) begin
                id = int'($urandom % 1024);
                d = int'($urandom);
            end else begin
                id = 'h108 + 16 * t + int'($urandom % 8);
                d = int'($urandom);
            end
            wr(id, d);
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule